// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Claim and Completion

This block collects 52 level-style interrupt requests and presents a single prioritised request to one processor. Each source has a small priority value and an enable bit, and one threshold value masks every source whose priority does not exceed it. A source that is raised latches a pending flag, so a brief pulse is enough to register a request.

Software takes ownership of a request by reading the claim register. That read returns the identifier of the best eligible source: the highest priority wins, and the lower identifier wins a tie. The read also clears that source's pending flag and marks the source as being serviced. Writing the same identifier back to the claim register ends the service, and only then can the source latch a new request. Identifier 0 is reserved and means "nothing to claim".

Top module: `irq_hub`

## Requirements
- R1: After reset, all priorities, enables, pending flags, in-service flags and the threshold are zero, and `irq_out` is low.
- R2: The priority of source n (1..52) is a 3-bit field in bits [2:0] of the word at byte offset 4*n. The upper bits of that word read as zero. The word at offset 0 is reserved: it reads as zero and ignores writes.
- R3: The enable bit of source n is bit n%32 of the word at offset 0x2000 + 4*(n/32). Bit 0 of the first word, and every bit above source 52, reads as zero.
- R4: The pending flags use the same packing as the enables, starting at offset 0x1000. A source input that is high for at least one cycle sets the flag, and the flag stays set after the input falls. Bus writes to the pending words have no effect.
- R5: The threshold is a 3-bit field at offset 0x200000. A source is eligible only when it is pending, enabled, and its priority is strictly greater than the threshold. A source with priority 0 is therefore never eligible.
- R6: A read of offset 0x200004 returns the eligible source with the highest priority, with the lower identifier winning a tie, and clears that source's pending flag. It returns 0 when no source is eligible.
- R7: A claimed source cannot become pending again, even with its input held high, until a write of its identifier to offset 0x200004 completes it. After completion, a source whose input is still high becomes pending again.
- R8: A completion write whose value is not the identifier of a source in service has no effect. This includes values with any bit set above bit 5.
- R9: `irq_out` is high exactly when at least one source is eligible.
- R10: Read data and `rsp_valid` appear on the clock edge that follows the cycle of the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | 52 | Interrupt inputs, bit n is source n |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
On every cycle the assertions check four things: `irq_out` agrees with the arbiter's winner, any winner is truly eligible above the threshold, no source is both pending and in service, and a claim moves its source from pending to in service. They also check that a stray completion leaves every in-service flag unchanged and that reads are answered one cycle later. Whether the winner is the best choice, how ties between equal priorities are broken, the register field packing, and the effect of a held input before and after completion can only be shown by the bench. The bench sweeps every threshold over a full set of latched requests and compares each claim with its own model.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W     = 22;
  localparam int REGION_LSB = 12;
  localparam int SLOT_W     = REGION_LSB - 2;
  localparam int RGN_W      = ADDR_W - REGION_LSB;

  localparam logic [RGN_W-1:0]  RGN_PRIO  = RGN_W'(0);
  localparam logic [RGN_W-1:0]  RGN_PEND  = RGN_W'(1);
  localparam logic [RGN_W-1:0]  RGN_EN    = RGN_W'(2);
  localparam logic [ADDR_W-1:0] OFS_THR   = 22'h200000;
  localparam logic [ADDR_W-1:0] OFS_CLAIM = 22'h200004;

  function automatic logic [RGN_W-1:0] region_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:REGION_LSB];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[REGION_LSB-1:2];
  endfunction

  function automatic int words_for(input int nsrc);
    return (nsrc + 32) / 32;
  endfunction
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter int NSRC = 52,
  parameter int ID_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC:1]   src_level,
  input  logic            claim_fire,
  input  logic [ID_W-1:0] claim_id,
  input  logic            done_fire,
  input  logic [ID_W-1:0] done_id,
  output logic [NSRC:0]   pend,
  output logic [NSRC:0]   insvc
);
  assign pend[0]  = 1'b0;
  assign insvc[0] = 1'b0;

  for (genvar i = 1; i <= NSRC; i++) begin : g_src
    logic pend_q, svc_q;
    logic take, release_now;
    assign take        = claim_fire && (claim_id == ID_W'(i));
    assign release_now = done_fire && (done_id == ID_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        svc_q  <= 1'b0;
      end else if (take) begin
        pend_q <= 1'b0;
        svc_q  <= 1'b1;
      end else begin
        if (release_now) svc_q <= 1'b0;
        if (src_level[i] && !svc_q) pend_q <= 1'b1;
      end
    end

    assign pend[i]  = pend_q;
    assign insvc[i] = svc_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = 52,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 6
) (
  input  logic [NSRC:1]             pend,
  input  logic [NSRC:1]             en,
  input  logic [NSRC*PRIO_W-1:0]    prio_vec,
  input  logic [PRIO_W-1:0]         thr,
  output logic [ID_W-1:0]           win_id,
  output logic                      any_elig
);
  function automatic logic [PRIO_W-1:0] prio_at(input logic [NSRC*PRIO_W-1:0] v,
                                                input int id);
    return v[(id-1)*PRIO_W +: PRIO_W];
  endfunction

  logic [NSRC:1] elig;
  for (genvar i = 1; i <= NSRC; i++) begin : g_elig
    assign elig[i] = pend[i] && en[i] && (prio_at(prio_vec, i) > thr);
  end
  assign any_elig = |elig;

  logic [PRIO_W-1:0] best_p;
  always_comb begin
    best_p = '0;
    win_id = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (elig[i] && (prio_at(prio_vec, i) > best_p)) begin
        best_p = prio_at(prio_vec, i);
        win_id = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NSRC   = 52,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_level,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              irq_out
);
  localparam int NWORD = words_for(NSRC);
  localparam int EXT_W = NWORD * 32;

  logic wr_en, rd_en, aligned;
  logic [RGN_W-1:0]  rgn;
  logic [SLOT_W-1:0] slot;
  int                slot_i;
  logic hit_prio, hit_pend, hit_en, hit_thr, hit_claim;

  assign wr_en   = req_valid && req_write;
  assign rd_en   = req_valid && !req_write;
  assign aligned = (req_addr[1:0] == 2'b00);
  assign rgn     = region_of(req_addr);
  assign slot    = slot_of(req_addr);
  assign slot_i  = int'(slot);

  assign hit_prio  = aligned && (rgn == RGN_PRIO) && (slot_i >= 1) && (slot_i <= NSRC);
  assign hit_pend  = aligned && (rgn == RGN_PEND) && (slot_i < NWORD);
  assign hit_en    = aligned && (rgn == RGN_EN)   && (slot_i < NWORD);
  assign hit_thr   = (req_addr == OFS_THR);
  assign hit_claim = (req_addr == OFS_CLAIM);

  // priority registers
  logic [(NSRC+1)*PRIO_W-1:0] prio_flat;
  assign prio_flat[PRIO_W-1:0] = '0;
  for (genvar i = 1; i <= NSRC; i++) begin : g_prio
    logic [PRIO_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr_en && hit_prio && slot_i == i) q <= req_wdata[PRIO_W-1:0];
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = q;
  end

  // enable bits
  logic [NSRC:0] en_vec;
  assign en_vec[0] = 1'b0;
  for (genvar i = 1; i <= NSRC; i++) begin : g_en
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else if (wr_en && hit_en && slot_i == i / 32) q <= req_wdata[i % 32];
    end
    assign en_vec[i] = q;
  end

  // threshold
  logic [PRIO_W-1:0] thr_q;
  always_ff @(posedge clk) begin
    if (!rst_n) thr_q <= '0;
    else if (wr_en && hit_thr) thr_q <= req_wdata[PRIO_W-1:0];
  end

  // claim / completion events
  logic            claim_fire, done_fire;
  logic [ID_W-1:0] claim_id, done_id, win_id;
  logic            any_elig;
  logic [NSRC:0]   pend_vec, insvc_vec;

  assign claim_fire = rd_en && hit_claim;
  assign claim_id   = win_id;
  assign done_fire  = wr_en && hit_claim && (req_wdata[31:ID_W] == '0);
  assign done_id    = req_wdata[ID_W-1:0];

  irq_gateway #(.NSRC(NSRC), .ID_W(ID_W)) u_gateway (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_level  (src_level),
    .claim_fire (claim_fire),
    .claim_id   (claim_id),
    .done_fire  (done_fire),
    .done_id    (done_id),
    .pend       (pend_vec),
    .insvc      (insvc_vec)
  );

  irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arbiter (
    .pend     (pend_vec[NSRC:1]),
    .en       (en_vec[NSRC:1]),
    .prio_vec (prio_flat[(NSRC+1)*PRIO_W-1:PRIO_W]),
    .thr      (thr_q),
    .win_id   (win_id),
    .any_elig (any_elig)
  );

  assign irq_out = any_elig;

  // read path
  logic [EXT_W-1:0] pend_ext, en_ext;
  logic [31:0]      rd_word;
  assign pend_ext = EXT_W'(pend_vec);
  assign en_ext   = EXT_W'(en_vec);

  always_comb begin
    rd_word = '0;
    if (hit_prio)       rd_word[PRIO_W-1:0] = prio_flat[slot_i*PRIO_W +: PRIO_W];
    else if (hit_pend)  rd_word = pend_ext[slot_i*32 +: 32];
    else if (hit_en)    rd_word = en_ext[slot_i*32 +: 32];
    else if (hit_thr)   rd_word[PRIO_W-1:0] = thr_q;
    else if (hit_claim) rd_word[ID_W-1:0] = win_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NSRC   = 52,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NSRC:0]              pend,
  input logic [NSRC:0]              insvc,
  input logic [NSRC:0]              en,
  input logic [(NSRC+1)*PRIO_W-1:0] prio_flat,
  input logic [PRIO_W-1:0]          thr,
  input logic [ID_W-1:0]            win_id,
  input logic                       irq_out,
  input logic                       claim_fire,
  input logic [ID_W-1:0]            claim_id,
  input logic                       done_fire,
  input logic [ID_W-1:0]            done_id,
  input logic                       req_valid,
  input logic                       req_write,
  input logic                       rsp_valid
);
  AST_IRQ_TRACKS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (win_id != '0)); // R9

  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id != '0) |-> (pend[win_id] && en[win_id] &&
                        prio_flat[win_id*PRIO_W +: PRIO_W] > thr)); // R5

  AST_CLAIM_MOVES_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && claim_id != '0) |=> (!pend[$past(claim_id)] && insvc[$past(claim_id)])); // R6

  AST_PEND_SVC_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & insvc) == '0); // R7

  AST_STRAY_DONE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_fire && (int'(done_id) > NSRC || !insvc[done_id])) |=> $stable(insvc)); // R8

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R10

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R10
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pend       (pend_vec),
  .insvc      (insvc_vec),
  .en         (en_vec),
  .prio_flat  (prio_flat),
  .thr        (thr_q),
  .win_id     (win_id),
  .irq_out    (irq_out),
  .claim_fire (claim_fire),
  .claim_id   (claim_id),
  .done_fire  (done_fire),
  .done_id    (done_id),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid)
);

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;
  localparam int NS = 52;
  localparam logic [21:0] A_PEND  = 22'h001000;
  localparam logic [21:0] A_EN    = 22'h002000;
  localparam logic [21:0] A_THR   = 22'h200000;
  localparam logic [21:0] A_CLAIM = 22'h200004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS:1] src = '0;
  logic        v = 1'b0, w = 1'b0;
  logic [21:0] a = '0;
  logic [31:0] d = '0;
  logic        rv, irq;
  logic [31:0] rdat;

  always #5 clk = ~clk;

  irq_hub u_irq_hub (
    .clk(clk), .rst_n(rst_n), .src_level(src),
    .req_valid(v), .req_write(w), .req_addr(a), .req_wdata(d),
    .rsp_valid(rv), .rsp_rdata(rdat), .irq_out(irq)
  );

  int total = 0, bad = 0;
  bit [NS:0] m_pend = '0, m_svc = '0, m_en = '0;
  int m_prio[NS+1];
  int m_thr = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [21:0] addr, input logic [31:0] data);
    @(negedge clk);
    v = 1'b1; w = 1'b1; a = addr; d = data;
    @(negedge clk);
    v = 1'b0; w = 1'b0;
  endtask

  task automatic bus_rd(input logic [21:0] addr, output logic [31:0] data, output logic valid);
    @(negedge clk);
    v = 1'b1; w = 1'b0; a = addr;
    @(negedge clk);
    v = 1'b0;
    data = rdat; valid = rv;
  endtask

  // model: scan priorities from the top, lower id first inside a level
  function automatic int pick();
    for (int p = 7; p > m_thr; p--)
      for (int i = 1; i <= NS; i++)
        if (m_pend[i] && m_en[i] && m_prio[i] == p) return i;
    return 0;
  endfunction

  function automatic logic [31:0] pack(input bit [NS:0] vec, input int wsel);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++)
      if (wsel*32 + b <= NS) r[b] = vec[wsel*32 + b];
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic gv;
    for (int i = 0; i <= NS; i++) m_prio[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 idle response
    check("R1 irq_out", {31'b0, irq}, 32'h0);
    check("R10 idle rsp_valid", {31'b0, rv}, 32'h0);
    for (int i = 1; i <= NS; i++) begin
      bus_rd(22'(4*i), got, gv);
      check("R1 prio", got, 32'h0);
    end
    check("R10 rsp_valid after read", {31'b0, gv}, 32'h1);
    for (int k = 0; k < 2; k++) begin
      bus_rd(A_PEND + 22'(4*k), got, gv); check("R1 pending", got, 32'h0);
      bus_rd(A_EN + 22'(4*k), got, gv);   check("R1 enable", got, 32'h0);
    end
    bus_rd(A_THR, got, gv);   check("R1 threshold", got, 32'h0);
    bus_rd(A_CLAIM, got, gv); check("R1 claim empty", got, 32'h0);

    // R2 priority registers
    for (int i = 1; i <= NS; i++) begin
      m_prio[i] = (i*3) % 8;
      bus_wr(22'(4*i), {29'h1FFFFFFF, 3'(m_prio[i])});
    end
    for (int i = 1; i <= NS; i++) begin
      bus_rd(22'(4*i), got, gv);
      check("R2 prio readback", got, 32'(m_prio[i]));
    end
    bus_wr(22'h0, 32'h7);
    bus_rd(22'h0, got, gv);
    check("R2 reserved word", got, 32'h0);

    // R3 enables, source 13 left disabled
    bus_wr(A_EN, 32'hFFFF_DFFF);
    bus_wr(A_EN + 22'd4, 32'hFFFF_FFFF);
    for (int i = 1; i <= NS; i++) m_en[i] = (i != 13);
    bus_rd(A_EN, got, gv);         check("R3 enable word0", got, 32'hFFFF_DFFE);
    bus_rd(A_EN + 22'd4, got, gv); check("R3 enable word1", got, 32'h001F_FFFF);

    // R5 threshold register width
    bus_wr(A_THR, 32'hFFFF_FFFD);
    bus_rd(A_THR, got, gv);
    check("R5 threshold readback", got, 32'h5);

    // R4 R5 R6 R9 sweep every threshold over a full set of requests
    for (int t = 7; t >= 0; t--) begin
      m_thr = t;
      bus_wr(A_THR, 32'(t));
      @(negedge clk); src = '1;
      @(negedge clk); src = '0;
      for (int i = 1; i <= NS; i++) if (!m_svc[i]) m_pend[i] = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        bus_rd(A_PEND + 22'(4*k), got, gv);
        check("R4 pending latched", got, pack(m_pend, k));
      end
      for (int n = 0; n < 60; n++) begin
        int exp_id;
        exp_id = pick();
        check("R9 irq_out before claim", {31'b0, irq}, {31'b0, exp_id != 0});
        bus_rd(A_CLAIM, got, gv);
        check("R6 claim id", got, 32'(exp_id));
        if (exp_id == 0) break;
        m_pend[exp_id] = 1'b0;
        m_svc[exp_id]  = 1'b1;
      end
      for (int i = 1; i <= NS; i++)
        if (m_svc[i]) begin
          bus_wr(A_CLAIM, 32'(i));
          m_svc[i] = 1'b0;
        end
    end
    // leftovers: priority-zero sources and the disabled one (R5)
    check("R5 prio zero never raises", {31'b0, irq}, 32'h0);

    // R4 writes to pending words ignored
    bus_wr(A_PEND, 32'h0);
    bus_wr(A_PEND + 22'd4, 32'hFFFF_FFFF);
    bus_rd(A_PEND, got, gv);         check("R4 write ignored w0", got, pack(m_pend, 0));
    bus_rd(A_PEND + 22'd4, got, gv); check("R4 write ignored w1", got, pack(m_pend, 1));

    // R7 R8 held input on source 5 (priority 7)
    bus_wr(A_EN, 32'h20);
    bus_wr(A_EN + 22'd4, 32'h0);
    for (int i = 0; i <= NS; i++) m_en[i] = (i == 5);
    m_thr = 0;
    bus_wr(A_THR, 32'h0);
    @(negedge clk); src[5] = 1'b1;
    m_pend[5] = 1'b1;
    @(negedge clk);
    bus_rd(A_CLAIM, got, gv);
    check("R6 claim held source", got, 32'h5);
    m_pend[5] = 1'b0; m_svc[5] = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(A_PEND, got, gv);
    check("R7 no re-pend while in service", got, pack(m_pend, 0));
    check("R7 irq low while in service", {31'b0, irq}, 32'h0);
    bus_wr(A_CLAIM, 32'h7);
    bus_wr(A_CLAIM, 32'h0);
    bus_wr(A_CLAIM, 32'h45);
    repeat (3) @(negedge clk);
    bus_rd(A_PEND, got, gv);
    check("R8 stray completion ignored", got, pack(m_pend, 0));
    bus_rd(A_CLAIM, got, gv);
    check("R8 still in service", got, 32'h0);
    bus_wr(A_CLAIM, 32'h5);
    m_svc[5] = 1'b0; m_pend[5] = 1'b1;
    bus_rd(A_PEND, got, gv);
    check("R7 re-pend after completion", got, pack(m_pend, 0));
    check("R9 irq after completion", {31'b0, irq}, 32'h1);
    src[5] = 1'b0;
    bus_rd(A_CLAIM, got, gv);
    check("R6 reclaim", got, 32'h5);
    bus_wr(A_CLAIM, 32'h5);
    bus_rd(A_CLAIM, got, gv);
    check("R6 empty after release", got, 32'h0);
    check("R9 irq low at end", {31'b0, irq}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule